// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block keeps a small, fully associative set of virtual-page to physical-frame mappings, the results of earlier page-table walks. Every stored mapping carries the process-context identifier that was current when it was filled. A lookup hits only when both the virtual page number and the identifier match. An operating system can therefore change the current identifier on a context switch and leave every cached mapping in place.

The requester presents a page number on the lookup port. In the same cycle it gets a hit with the frame number and the writable, user-access and dirty bits. On a miss it gets a miss flag and the page number the walker must resolve. The walker answers through the fill port. The cache does not watch page-table memory, so a stored mapping stays valid until software removes it with an invalidate command. The command can name one page of the current context, every mapping of one identifier, or the whole cache. The page walk itself and memory are outside this block.

Top module: `ctx_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses until a fill has been made.
- R2: A lookup with `lk_valid` high hits in the same cycle when a valid entry holds `lk_vpn` under `cur_ctx`. It returns that entry's frame number and its writable, user and dirty bits. At most one entry ever matches a given page and identifier.
- R3: A lookup that does not hit raises `lk_miss` and presents `lk_vpn` on `miss_vpn`. `lk_hit` and `lk_miss` are never high together, and both are low when `lk_valid` is low.
- R4: An entry filled under one identifier never hits under another identifier. Changing `cur_ctx` removes nothing, so going back to the first identifier hits again.
- R5: A lookup with `lk_write` high that finds an entry whose dirty bit is 0 is reported as a miss and not as a hit.
- R6: A fill writes the tag `cur_ctx` together with the supplied fields. It goes to the entry already holding the same page and identifier if there is one. Otherwise it goes to the lowest-indexed invalid entry. Otherwise it goes to the entry at a replacement pointer, which starts at 0 after reset and advances by one, wrapping after the last entry, only when a valid entry is evicted this way.
- R7: The command with `inv_kind` = 2'b00 clears every entry whose page equals `inv_vpn` and whose identifier equals `cur_ctx`.
- R8: The command with `inv_kind` = 2'b01 clears every entry whose identifier equals `inv_ctx`, whatever its page.
- R9: The command with `inv_kind` = 2'b10 clears every entry. The code 2'b11 changes nothing. Each command takes effect at the next clock edge.
- R10: When a fill and an invalidate arrive in the same cycle, the invalidate acts on the contents from before that cycle. The fill slot is chosen from those same contents, and the filled entry is valid afterwards even if the invalidate named it.
- R11: Without an invalidate or an eviction, a valid entry stays valid for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ctx | input | 12 | Current process-context identifier |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number looked up |
| lk_write | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss, walker request |
| miss_vpn | output | 20 | Page number for the walker |
| lk_pfn | output | 20 | Frame number of the hit entry |
| lk_rw | output | 1 | Writable bit of the hit entry |
| lk_us | output | 1 | User-access bit of the hit entry |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| fill_valid | input | 1 | Walker fill request |
| fill_vpn | input | 20 | Page number of the fill |
| fill_pfn | input | 20 | Frame number of the fill |
| fill_rw | input | 1 | Writable bit of the fill |
| fill_us | input | 1 | User-access bit of the fill |
| fill_dirty | input | 1 | Dirty bit of the fill |
| inv_valid | input | 1 | Invalidate command strobe |
| inv_kind | input | 2 | 00 page, 01 context, 10 all, 11 none |
| inv_vpn | input | 20 | Page for a page invalidate |
| inv_ctx | input | 12 | Identifier for a context invalidate |

## Verification
A fill and an invalidate can land in the same cycle. They compete for the same entry when the fill refreshes a mapping that the command is removing, or when the fill takes a slot that the command frees. The bench provokes this with directed cases, such as a page invalidate paired with a fill of that same page, and with a random phase over a small page and identifier space where both strobes are often high together. A behavioural model applies the invalidate to the old contents, places the fill using those same old contents, and compares every lookup output with it on every cycle. A wrong ordering shows up as a missing or a stale hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int CTX_W = 12;
    parameter int VPN_W = 20;
    parameter int PFN_W = 20;

    typedef enum logic [1:0] {
        INV_PAGE = 2'b00,
        INV_CTX  = 2'b01,
        INV_ALL  = 2'b10,
        INV_NONE = 2'b11
    } inv_kind_e;

    typedef struct packed {
        logic             valid;
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             rw;
        logic             us;
        logic             dirty;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]            valid_vec,
    input  logic [N-1:0][VPN_W-1:0] vpn_vec,
    input  logic [N-1:0][CTX_W-1:0] ctx_vec,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [CTX_W-1:0]        key_ctx,
    output logic [N-1:0]            hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (vpn_vec[g] == key_vpn) && (ctx_vec[g] == key_ctx);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     same_vec,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output logic             evict
);
    logic             found_same;
    logic             found_free;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        found_same = 1'b0;
        found_free = 1'b0;
        same_idx   = '0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same_vec[i]) begin
                found_same = 1'b1;
                same_idx   = IDX_W'(i);
            end
            if (!valid_vec[i]) begin
                found_free = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        if (found_same) begin
            slot  = same_idx;
            evict = 1'b0;
        end else if (found_free) begin
            slot  = free_idx;
            evict = 1'b0;
        end else begin
            slot  = rr_ptr;
            evict = 1'b1;
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] cur_ctx,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [VPN_W-1:0] miss_vpn,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_rw,
    output logic             lk_us,
    output logic             lk_dirty,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_rw,
    input  logic             fill_us,
    input  logic             fill_dirty,
    input  logic             inv_valid,
    input  logic [1:0]       inv_kind,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [CTX_W-1:0] inv_ctx
);
    typedef struct packed {
        tlb_entry_t [N_ENTRIES-1:0] ent;
        logic [IDX_W-1:0]           rr;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [N_ENTRIES-1:0]            valid_vec;
    logic [N_ENTRIES-1:0][VPN_W-1:0] vpn_vec;
    logic [N_ENTRIES-1:0][CTX_W-1:0] ctx_vec;
    logic [N_ENTRIES-1:0]            look_vec;
    logic [N_ENTRIES-1:0]            same_vec;
    logic [IDX_W-1:0]                fill_slot;
    logic                            fill_evict;
    tlb_entry_t                      sel;
    inv_kind_e                       kind;

    always_comb begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            valid_vec[i] = st_q.ent[i].valid;
            vpn_vec[i]   = st_q.ent[i].vpn;
            ctx_vec[i]   = st_q.ent[i].ctx;
        end
    end

    tlb_match #(.N(N_ENTRIES)) u_look_match (
        .valid_vec(valid_vec), .vpn_vec(vpn_vec), .ctx_vec(ctx_vec),
        .key_vpn(lk_vpn), .key_ctx(cur_ctx), .hit_vec(look_vec)
    );

    tlb_match #(.N(N_ENTRIES)) u_fill_match (
        .valid_vec(valid_vec), .vpn_vec(vpn_vec), .ctx_vec(ctx_vec),
        .key_vpn(fill_vpn), .key_ctx(cur_ctx), .hit_vec(same_vec)
    );

    tlb_victim #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid_vec(valid_vec), .same_vec(same_vec), .rr_ptr(st_q.rr),
        .slot(fill_slot), .evict(fill_evict)
    );

    // Lookup path: OR-select the single matching entry
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (look_vec[i]) sel = sel | st_q.ent[i];
        end
        lk_hit   = lk_valid && (|look_vec) && !(lk_write && !sel.dirty);
        lk_miss  = lk_valid && !lk_hit;
        miss_vpn = lk_vpn;
        lk_pfn   = sel.pfn;
        lk_rw    = sel.rw;
        lk_us    = sel.us;
        lk_dirty = sel.dirty;
    end

    // Next state: invalidate old contents, then place the fill
    always_comb begin
        st_d = st_q;
        kind = inv_kind_e'(inv_kind);
        if (inv_valid) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                unique case (kind)
                    INV_PAGE: if (st_q.ent[i].vpn == inv_vpn && st_q.ent[i].ctx == cur_ctx)
                                  st_d.ent[i].valid = 1'b0;
                    INV_CTX:  if (st_q.ent[i].ctx == inv_ctx)
                                  st_d.ent[i].valid = 1'b0;
                    INV_ALL:  st_d.ent[i].valid = 1'b0;
                    default:  ;
                endcase
            end
        end
        if (fill_valid) begin
            st_d.ent[fill_slot].valid = 1'b1;
            st_d.ent[fill_slot].ctx   = cur_ctx;
            st_d.ent[fill_slot].vpn   = fill_vpn;
            st_d.ent[fill_slot].pfn   = fill_pfn;
            st_d.ent[fill_slot].rw    = fill_rw;
            st_d.ent[fill_slot].us    = fill_us;
            st_d.ent[fill_slot].dirty = fill_dirty;
            if (fill_evict)
                st_d.rr = (st_q.rr == IDX_W'(N_ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Assertions
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_vec == '0));

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_vec));

    assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> st_q.ent[$past(fill_slot)].valid);

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fill_evict) |=> $stable(st_q.rr));

    assert_inv_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_kind == 2'b10 && !fill_valid) |=> (valid_vec == '0));

    assert_persist_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_valid && !fill_valid) |=> $stable(valid_vec));
endmodule

// File: tb/ctx_tlb_tb_top.sv
`timescale 1ns/1ps
module ctx_tlb_tb_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cur_ctx = '0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_miss, lk_rw, lk_us, lk_dirty;
    logic [19:0] miss_vpn, lk_pfn;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic        fill_rw = 1'b0, fill_us = 1'b0, fill_dirty = 1'b0;
    logic        inv_valid = 1'b0;
    logic [1:0]  inv_kind = 2'b11;
    logic [19:0] inv_vpn = '0;
    logic [11:0] inv_ctx = '0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ctx_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .cur_ctx(cur_ctx),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .miss_vpn(miss_vpn),
        .lk_pfn(lk_pfn), .lk_rw(lk_rw), .lk_us(lk_us), .lk_dirty(lk_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_rw(fill_rw), .fill_us(fill_us), .fill_dirty(fill_dirty),
        .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_vpn(inv_vpn), .inv_ctx(inv_ctx)
    );

    // Behavioural reference model
    bit       m_v[N];
    int       m_ctx[N], m_vpn[N], m_pfn[N];
    bit       m_rw[N], m_us[N], m_d[N];
    int       m_rr = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int find(input int vpn, input int ctx);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_ctx[i] == ctx) return i;
        return -1;
    endfunction

    task automatic compare(input string tag);
        int  k;
        bit  eh, em;
        k  = find(int'(lk_vpn), int'(cur_ctx));
        eh = lk_valid && k >= 0 && !(lk_write && !m_d[k]);
        em = lk_valid && !eh;
        check(lk_hit == eh, tag, "hit", lk_hit, eh);
        check(lk_miss == em, tag, "miss", lk_miss, em);
        if (em) check(miss_vpn == lk_vpn, tag, "miss_vpn", miss_vpn, lk_vpn);
        if (eh) begin
            check(lk_pfn == 20'(m_pfn[k]), tag, "pfn", lk_pfn, m_pfn[k]);
            check({lk_rw, lk_us, lk_dirty} == {m_rw[k], m_us[k], m_d[k]}, tag, "perm",
                  {lk_rw, lk_us, lk_dirty}, {m_rw[k], m_us[k], m_d[k]});
        end
    endtask

    task automatic model_update();
        bit nv[N];
        int slot;
        bit ev;
        slot = find(int'(fill_vpn), int'(cur_ctx));
        ev = 1'b0;
        if (slot < 0)
            for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin slot = m_rr; ev = 1'b1; end
        for (int i = 0; i < N; i++) begin
            nv[i] = m_v[i];
            if (inv_valid) begin
                if (inv_kind == 2'b00 && m_vpn[i] == int'(inv_vpn) && m_ctx[i] == int'(cur_ctx)) nv[i] = 1'b0;
                if (inv_kind == 2'b01 && m_ctx[i] == int'(inv_ctx)) nv[i] = 1'b0;
                if (inv_kind == 2'b10) nv[i] = 1'b0;
            end
        end
        if (fill_valid) begin
            nv[slot] = 1'b1; m_ctx[slot] = int'(cur_ctx); m_vpn[slot] = int'(fill_vpn);
            m_pfn[slot] = int'(fill_pfn); m_rw[slot] = fill_rw; m_us[slot] = fill_us;
            m_d[slot] = fill_dirty;
            if (ev) m_rr = (m_rr + 1) % N;
        end
        for (int i = 0; i < N; i++) m_v[i] = nv[i];
    endtask

    // One cycle: inputs already set after negedge; compare, then predict
    task automatic cycle(input string tag);
        #1;
        compare(tag);
        model_update();
        @(negedge clk);
        fill_valid = 1'b0; inv_valid = 1'b0; lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic do_look(input int vpn, input bit wr, input string tag);
        lk_valid = 1'b1; lk_vpn = 20'(vpn); lk_write = wr;
        cycle(tag);
    endtask

    task automatic do_fill(input int vpn, input int pfn, input bit d, input string tag);
        fill_valid = 1'b1; fill_vpn = 20'(vpn); fill_pfn = 20'(pfn);
        fill_rw = 1'b1; fill_us = vpn[0]; fill_dirty = d;
        cycle(tag);
    endtask

    task automatic do_inv(input logic [1:0] k, input int vpn, input int ctx, input string tag);
        inv_valid = 1'b1; inv_kind = k; inv_vpn = 20'(vpn); inv_ctx = 12'(ctx);
        cycle(tag);
    endtask

    initial begin
        #600000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        for (int v = 0; v < 4; v++) do_look(v, 1'b0, "R1");
        do_look(7, 1'b0, "R3");
        cycle("R3"); // idle lookup: both low

        // R2 fill and hit
        cur_ctx = 12'd1;
        do_fill(5, 'h1234, 1'b1, "R2");
        do_look(5, 1'b0, "R2");
        do_look(5, 1'b1, "R2");
        // R4 context switch keeps entries
        cur_ctx = 12'd2;
        do_look(5, 1'b0, "R4");
        cur_ctx = 12'd1;
        do_look(5, 1'b0, "R4");
        // R5 write on clean entry
        do_fill(6, 'h0abc, 1'b0, "R5");
        do_look(6, 1'b1, "R5");
        do_look(6, 1'b0, "R5");
        do_fill(6, 'h0abc, 1'b1, "R6"); // refill same page sets dirty, same slot
        do_look(6, 1'b1, "R6");
        // R7 page invalidate only current context
        cur_ctx = 12'd2;
        do_fill(5, 'h2222, 1'b1, "R7");
        do_inv(2'b00, 5, 0, "R7");
        do_look(5, 1'b0, "R7");
        cur_ctx = 12'd1;
        do_look(5, 1'b0, "R7");
        // R8 context invalidate
        cur_ctx = 12'd3;
        do_fill(9, 'h3333, 1'b1, "R8");
        do_inv(2'b01, 0, 1, "R8");
        do_look(9, 1'b0, "R8");
        cur_ctx = 12'd1;
        do_look(6, 1'b0, "R8");
        // R9 code 11 no effect, then all
        cur_ctx = 12'd3;
        do_inv(2'b11, 9, 3, "R9");
        do_look(9, 1'b0, "R9");
        do_inv(2'b10, 0, 0, "R9");
        do_look(9, 1'b0, "R9");
        // R6 round robin over a full cache
        cur_ctx = 12'd4;
        for (int v = 0; v < N; v++) do_fill(v + 100, v + 500, 1'b1, "R6");
        for (int v = 0; v < 3; v++) do_fill(v + 200, v + 700, 1'b1, "R6");
        for (int v = 0; v < 4; v++) do_look(v + 100, 1'b0, "R6");
        for (int v = 0; v < 3; v++) do_look(v + 200, 1'b0, "R6");
        // R10 fill and page invalidate of the same page in one cycle
        fill_valid = 1'b1; fill_vpn = 20'd103; fill_pfn = 20'h0f0f; fill_dirty = 1'b1;
        inv_valid = 1'b1; inv_kind = 2'b00; inv_vpn = 20'd103;
        cycle("R10");
        do_look(103, 1'b0, "R10");
        // R10 fill together with invalidate-all
        fill_valid = 1'b1; fill_vpn = 20'd300; fill_pfn = 20'h00aa; fill_dirty = 1'b0;
        inv_valid = 1'b1; inv_kind = 2'b10;
        cycle("R10");
        do_look(300, 1'b0, "R10");
        do_look(104, 1'b0, "R10");
        // R11 persistence over idle cycles
        repeat (50) cycle("R11");
        do_look(300, 1'b0, "R11");

        // Random phase: small spaces so everything collides
        for (int n = 0; n < 6000; n++) begin
            cur_ctx    = 12'($urandom_range(0, 3));
            lk_valid   = $urandom_range(0, 3) != 0;
            lk_vpn     = 20'($urandom_range(0, 23));
            lk_write   = $urandom_range(0, 1);
            fill_valid = $urandom_range(0, 2) == 0;
            fill_vpn   = 20'($urandom_range(0, 23));
            fill_pfn   = 20'($urandom);
            fill_rw    = $urandom_range(0, 1);
            fill_us    = $urandom_range(0, 1);
            fill_dirty = $urandom_range(0, 1);
            inv_valid  = $urandom_range(0, 9) == 0;
            inv_kind   = 2'($urandom_range(0, 3));
            if (inv_kind == 2'b10 && $urandom_range(0, 3) != 0) inv_kind = 2'b00;
            inv_vpn    = 20'($urandom_range(0, 23));
            inv_ctx    = 12'($urandom_range(0, 3));
            cycle("R10");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule